// File: doc/BRIEF.md
# MDIO Management Master

This block lets a host read and write the management registers of an Ethernet PHY over the two-wire MDC/MDIO link. The host uses a small word-addressed register bus to reach six registers: configuration, command, PHY/register address, write data, read data and indicator. The block generates MDC only while a frame is in flight. It drives MDIO through a split output/enable/input pin set, so an external tri-state pad can be attached, and it frames complete clause-22 transactions.

A write frame starts when the host stores a value in the write-data register. A read frame starts only when the command read bit goes from 0 to 1, so the host clears the bit before it sets it again. The host polls the indicator register for completion. That register has a busy flag that covers every frame and a not-valid flag that covers a read until its data is captured. A configuration write with the abort bit set stops any frame at once. A configuration write without that bit loads the MDC divider.

Top module: `mdio_mgmt_master`

## Requirements
- R1: The address register (offset 2) stores the PHY address in bits 12:8 and the register number in bits 4:0, and reads back in the same positions with all other bits zero.
- R2: A write to the write-data register (offset 3, value in bits 15:0) while idle launches a 64-bit frame, sent MSB first: 32 ones, start 01, opcode 01, PHY address, register number, turnaround 10, then the 16 data bits. mdio_oe is high for all 64 bits, and mdio_o changes only while MDC is low.
- R3: A write to the command register (offset 1) launches a read frame only when bit 0 is written as 1 and the stored bit is 0. A read frame carries opcode 10, and mdio_oe is low from the turnaround (bit 46) to the end of the frame.
- R4: In a read, mdio_i is sampled on each rising MDC edge of the 16 data bits, MSB first. The result appears in bits 15:0 of the read-data register (offset 4) when the frame ends.
- R5: Indicator register (offset 5) bit 0 (busy) is high from the clock edge that launches a frame until the frame ends.
- R6: Indicator bit 2 (not-valid) is set when a read launches and clears when the read data is captured or the frame is aborted. A write frame leaves it at zero.
- R7: The MDC period is 2*(div+1) clock cycles, where div is configuration bits 2:0. MDC and mdio_oe are low while idle.
- R8: A configuration write (offset 0) with bit 7 set aborts any frame. From the next cycle busy, not-valid, MDC and mdio_oe are all zero, and the divider is unchanged. A configuration write with bit 7 clear loads bits 2:0 into the divider, which reads back in the same bits. The divider resets to 7.
- R9: Writes to the address, write-data or command registers while busy are ignored: the frame in progress is unchanged, the registers read back their old values, and no new frame follows.
- R10: Busy lasts exactly 128*(div+1) clock cycles per frame, so it always deasserts within a bounded time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The checks assume that the host issues at most one register write per cycle. They also assume that the divider is not reprogrammed while a frame is busy, and that mdio_i changes only while MDC is low, as a PHY driving on the falling edge would do. The bench's PHY model changes mdio_i just after each falling MDC edge and holds it for the whole high phase. Divider writes happen only while the engine is idle, apart from the abort write. Random transactions pick divider values from 0 to 3 and mix them with directed cases: an abort, a repeated read bit, and writes issued while busy.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

   typedef enum logic [2:0] {
      SEL_CFG   = 3'd0,
      SEL_CMD   = 3'd1,
      SEL_ADDR  = 3'd2,
      SEL_WDATA = 3'd3,
      SEL_RDATA = 3'd4,
      SEL_IND   = 3'd5
   } reg_sel_e;

   localparam int PHY_W       = 5;
   localparam int REGN_W      = 5;
   localparam int DATA_W      = 16;
   localparam int PHY_LSB     = 8;
   localparam int CFG_ABORT   = 7;
   localparam int CMD_RD_BIT  = 0;
   localparam int IND_BUSY    = 0;
   localparam int IND_NV      = 2;
   localparam int HDR_BITS    = 32;  // start+op+phy+reg+ta+data

   localparam logic [1:0] SOF_CODE = 2'b01;
   localparam logic [1:0] OP_WRITE = 2'b01;
   localparam logic [1:0] OP_READ  = 2'b10;
   localparam logic [1:0] TA_WRITE = 2'b10;
   localparam logic [1:0] TA_READ  = 2'b11;

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
   parameter int DIV_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || cnt_q == div) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign tick = run && (cnt_q == div);
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
   import mdio_mgmt_pkg::*;
#(
   parameter int PRE_LEN     = 32,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              abort,
   input  logic              start,
   input  logic              start_rd,
   input  logic [PHY_W-1:0]  phy,
   input  logic [REGN_W-1:0] regn,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tick,
   input  logic              mdio_i,
   output logic              busy,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic              rd_end,
   output logic [DATA_W-1:0] rd_value
);
   localparam int FRAME_LEN = PRE_LEN + HDR_BITS;
   localparam int IDX_W     = $clog2(FRAME_LEN);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
   localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(PRE_LEN + 14);
   localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(PRE_LEN + 16);

   logic                 mdio_s;
   logic [FRAME_LEN-1:0] shreg_q;
   logic [IDX_W-1:0]     idx_q;
   logic                 rd_q;
   logic [DATA_W-1:0]    cap_q;
   logic                 frame_end;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign mdio_s = mdio_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sr_q;
      for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sr_q[g] <= 1'b1;
               else        sr_q[g] <= mdio_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sr_q[g] <= 1'b1;
               else        sr_q[g] <= sr_q[g-1];
            end
         end
      end
      assign mdio_s = sr_q[SYNC_STAGES-1];
   end

   assign frame_end = busy && tick && mdc && (idx_q == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         mdc     <= 1'b0;
         idx_q   <= '0;
         rd_q    <= 1'b0;
         shreg_q <= '1;
         cap_q   <= '0;
      end else if (abort) begin
         busy  <= 1'b0;
         mdc   <= 1'b0;
         idx_q <= '0;
      end else if (start && !busy) begin
         busy    <= 1'b1;
         mdc     <= 1'b0;
         idx_q   <= '0;
         rd_q    <= start_rd;
         shreg_q <= {{PRE_LEN{1'b1}}, SOF_CODE,
                     start_rd ? OP_READ : OP_WRITE, phy, regn,
                     start_rd ? TA_READ : TA_WRITE,
                     start_rd ? {DATA_W{1'b0}} : tx_data};
      end else if (busy && tick) begin
         if (!mdc) begin
            mdc <= 1'b1;
            if (rd_q && idx_q >= DATA_IDX) cap_q <= {cap_q[DATA_W-2:0], mdio_s};
         end else begin
            mdc <= 1'b0;
            if (idx_q == LAST_IDX) begin
               busy <= 1'b0;
            end else begin
               idx_q   <= idx_q + 1'b1;
               shreg_q <= {shreg_q[FRAME_LEN-2:0], 1'b1};
            end
         end
      end
   end

   assign mdio_o   = shreg_q[FRAME_LEN-1];
   assign mdio_oe  = busy && !(rd_q && idx_q >= TA_IDX);
   assign rd_end   = frame_end && rd_q;
   assign rd_value = cap_q;
endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
   import mdio_mgmt_pkg::*;
#(
   parameter int BUS_W   = 32,
   parameter int DIV_W   = 3,
   parameter int DIV_RST = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  reg_sel_e          sel,
   input  logic [BUS_W-1:0]  wdata,
   output logic [BUS_W-1:0]  rdata,
   input  logic              busy,
   input  logic              rd_end,
   input  logic [DATA_W-1:0] rd_value,
   output logic              abort,
   output logic              start,
   output logic              start_rd,
   output logic [PHY_W-1:0]  phy,
   output logic [REGN_W-1:0] regn,
   output logic [DATA_W-1:0] tx_data,
   output logic [DIV_W-1:0]  div,
   output logic              notvalid
);
   logic              cmd_q;
   logic [DATA_W-1:0] wd_q;
   logic [DATA_W-1:0] rd_q;
   logic              start_wr;

   assign abort    = we && sel == SEL_CFG && wdata[CFG_ABORT];
   assign start_wr = we && sel == SEL_WDATA && !busy;
   assign start_rd = we && sel == SEL_CMD && !busy && wdata[CMD_RD_BIT] && !cmd_q;
   assign start    = start_wr || start_rd;
   assign tx_data  = wdata[DATA_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div      <= DIV_W'(DIV_RST);
         cmd_q    <= 1'b0;
         phy      <= '0;
         regn     <= '0;
         wd_q     <= '0;
         rd_q     <= '0;
         notvalid <= 1'b0;
      end else begin
         if (we && sel == SEL_CFG && !wdata[CFG_ABORT]) div <= wdata[DIV_W-1:0];
         if (we && sel == SEL_CMD && !busy) cmd_q <= wdata[CMD_RD_BIT];
         if (we && sel == SEL_ADDR && !busy) begin
            phy  <= wdata[PHY_LSB +: PHY_W];
            regn <= wdata[REGN_W-1:0];
         end
         if (start_wr) wd_q <= wdata[DATA_W-1:0];
         if (rd_end) rd_q <= rd_value;
         if (abort || rd_end) notvalid <= 1'b0;
         else if (start_rd)   notvalid <= 1'b1;
      end
   end

   always_comb begin
      rdata = '0;
      unique case (sel)
         SEL_CFG:   rdata[DIV_W-1:0] = div;
         SEL_CMD:   rdata[CMD_RD_BIT] = cmd_q;
         SEL_ADDR: begin
            rdata[PHY_LSB +: PHY_W] = phy;
            rdata[REGN_W-1:0]       = regn;
         end
         SEL_WDATA: rdata[DATA_W-1:0] = wd_q;
         SEL_RDATA: rdata[DATA_W-1:0] = rd_q;
         SEL_IND: begin
            rdata[IND_BUSY] = busy;
            rdata[IND_NV]   = notvalid;
         end
         default:   rdata = '0;
      endcase
   end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
   import mdio_mgmt_pkg::*;
#(
   parameter int BUS_W       = 32,
   parameter int DIV_W       = 3,
   parameter int DIV_RST     = 7,
   parameter int PRE_LEN     = 32,
   parameter int SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [2:0]       reg_addr,
   input  logic [BUS_W-1:0] reg_wdata,
   output logic [BUS_W-1:0] reg_rdata,
   output logic             mdc,
   output logic             mdio_o,
   output logic             mdio_oe,
   input  logic             mdio_i
);
   if (DIV_W < 1 || DIV_W > 7) begin : g_bad_div
      $error("DIV_W must be 1..7");
   end
   if (DIV_RST < 0 || DIV_RST >= (1 << DIV_W)) begin : g_bad_rst
      $error("DIV_RST does not fit DIV_W");
   end
   if (PRE_LEN < 1 || PRE_LEN > 64) begin : g_bad_pre
      $error("PRE_LEN must be 1..64");
   end
   if (BUS_W < 16) begin : g_bad_bus
      $error("BUS_W must hold a 16-bit data word and the abort bit");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
      $error("SYNC_STAGES must be 0..3");
   end

   logic              eng_busy;
   logic              rd_end;
   logic [DATA_W-1:0] rd_value;
   logic              abort;
   logic              start;
   logic              start_rd;
   logic [PHY_W-1:0]  addr_phy;
   logic [REGN_W-1:0] addr_regn;
   logic [DATA_W-1:0] tx_data;
   logic [DIV_W-1:0]  div;
   logic              rd_notvalid;
   logic              tick;

   mdio_host_regs #(.BUS_W(BUS_W), .DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel_e'(reg_addr)),
      .wdata(reg_wdata), .rdata(reg_rdata), .busy(eng_busy), .rd_end(rd_end),
      .rd_value(rd_value), .abort(abort), .start(start), .start_rd(start_rd),
      .phy(addr_phy), .regn(addr_regn), .tx_data(tx_data), .div(div),
      .notvalid(rd_notvalid)
   );

   mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
      .clk(clk), .rst_n(rst_n), .run(eng_busy), .div(div), .tick(tick)
   );

   mdio_frame_eng #(.PRE_LEN(PRE_LEN), .SYNC_STAGES(SYNC_STAGES)) u_eng (
      .clk(clk), .rst_n(rst_n), .abort(abort), .start(start), .start_rd(start_rd),
      .phy(addr_phy), .regn(addr_regn), .tx_data(tx_data), .tick(tick),
      .mdio_i(mdio_i), .busy(eng_busy), .mdc(mdc), .mdio_o(mdio_o),
      .mdio_oe(mdio_oe), .rd_end(rd_end), .rd_value(rd_value)
   );
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk #(
   parameter int BUS_W   = 32,
   parameter int DIV_W   = 3,
   parameter int PRE_LEN = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_we,
   input logic [2:0]       reg_addr,
   input logic [BUS_W-1:0] reg_wdata,
   input logic             busy,
   input logic             notvalid,
   input logic             mdc,
   input logic             mdio_o,
   input logic             mdio_oe,
   input logic [4:0]       addr_phy,
   input logic [4:0]       addr_regn
);
   localparam int BOUND = (PRE_LEN + 32) * 2 * (1 << DIV_W);
   int unsigned busy_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_cnt <= 0;
      else if (busy) busy_cnt <= busy_cnt + 1;
      else           busy_cnt <= 0;
   end

   p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdc && !mdio_oe));

   p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == 3'd0 && reg_wdata[7]) |=> (!busy && !notvalid && !mdc));

   p_nv_with_launch_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(notvalid) |-> $rose(busy));

   p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_we && reg_addr == 3'd2) |=> $stable({addr_phy, addr_regn}));

   p_mdio_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

   p_busy_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy_cnt <= BOUND);
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk #(.BUS_W(BUS_W), .DIV_W(DIV_W), .PRE_LEN(PRE_LEN)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .busy(eng_busy), .notvalid(rd_notvalid), .mdc(mdc),
   .mdio_o(mdio_o), .mdio_oe(mdio_oe), .addr_phy(addr_phy), .addr_regn(addr_regn)
);

// File: tb/mdio_mgmt_master_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_master_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   logic [63:0] cap_o, cap_oe, phy_val;
   int          cap_n = 64;
   time         t_r0, t_r1;

   always #4 clk = ~clk;

   mdio_mgmt_master u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   // PHY model: capture on rising MDC, drive read data after falling MDC
   always @(posedge mdc) begin
      #1;
      if (cap_n < 64) begin
         cap_o[63-cap_n]  = mdio_o;
         cap_oe[63-cap_n] = mdio_oe;
         if (cap_n == 0) t_r0 = $time;
         if (cap_n == 1) t_r1 = $time;
         cap_n++;
      end
   end

   always @(negedge mdc) begin
      #1;
      if (cap_n >= 48 && cap_n < 64) mdio_i = phy_val[63-cap_n];
   end

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_idle(output int cyc);
      logic [31:0] v;
      cyc = 0;
      for (int i = 0; i < 5000; i++) begin
         rd(3'd5, v);
         if (v[0] == 1'b0) break;
         cyc++;
         @(negedge clk);
      end
   endtask

   function automatic logic [63:0] exp_frame(input bit is_rd, input logic [4:0] p,
                                             input logic [4:0] r, input logic [15:0] d);
      return {32'hFFFF_FFFF, 2'b01, is_rd ? 2'b10 : 2'b01, p, r,
              is_rd ? 2'b11 : 2'b10, is_rd ? 16'h0 : d};
   endfunction

   function automatic logic [63:0] oe_mask(input bit is_rd);
      return is_rd ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
   endfunction

   task automatic do_frame(input bit is_rd, input logic [4:0] p, input logic [4:0] r,
                           input logic [15:0] d, input logic [2:0] dv, input bit inject);
      logic [31:0] v;
      logic [63:0] m;
      int          cyc;
      wr(3'd0, {29'd0, dv});
      wr(3'd2, {19'd0, p, 3'd0, r});
      rd(3'd2, v);
      check("R1 address readback", {32'd0, v}, {51'd0, p, 3'd0, r});
      phy_val = {48'd0, d};
      cap_n = 0;
      if (is_rd) begin
         wr(3'd1, 32'd0);
         cap_n = 0;
         wr(3'd1, 32'd1);
      end else begin
         wr(3'd3, {16'd0, d});
      end
      rd(3'd5, v);
      check("R5 busy at launch", {63'd0, v[0]}, 64'd1);
      check("R6 notvalid at launch", {63'd0, v[2]}, {63'd0, is_rd});
      if (inject) begin
         wr(3'd2, 32'h0000_1F1F ^ {19'd0, p, 3'd0, r});
         wr(3'd3, 32'h0000_A5A5);
         wr(3'd1, is_rd ? 32'd0 : 32'd1);
      end
      wait_idle(cyc);
      if (!inject)
         check("R10 busy duration", 64'(cyc), 64'(128 * (int'(dv) + 1)));
      check("R7 mdc period", 64'(t_r1 - t_r0), 64'(16 * (int'(dv) + 1)));
      m = oe_mask(is_rd);
      check(is_rd ? "R3 read frame bits" : "R2 write frame bits",
            cap_o & m, exp_frame(is_rd, p, r, d) & m);
      check(is_rd ? "R3 read oe pattern" : "R2 write oe pattern", cap_oe, m);
      rd(3'd5, v);
      check("R6 indicator after frame", {32'd0, v}, 64'd0);
      if (is_rd) begin
         rd(3'd4, v);
         check("R4 read data", {32'd0, v}, {48'd0, d});
      end
      if (inject) begin
         rd(3'd2, v);
         check("R9 address unchanged", {32'd0, v}, {51'd0, p, 3'd0, r});
         rd(3'd1, v);
         check("R9 command unchanged", {32'd0, v}, {63'd0, is_rd});
         @(negedge clk);
         rd(3'd5, v);
         check("R9 no extra frame", {32'd0, v}, 64'd0);
      end
      rd(3'd1, v);
      if (v[0]) wr(3'd1, 32'd0);
   endtask

   initial begin
      logic [31:0] v;
      void'($urandom(32'd4242));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      rd(3'd5, v); check("R5 reset indicator", {32'd0, v}, 64'd0);
      rd(3'd0, v); check("R8 reset divider", {32'd0, v}, 64'd7);
      rd(3'd4, v); check("R4 reset read data", {32'd0, v}, 64'd0);
      check("R7 reset pins", {62'd0, mdc, mdio_oe}, 64'd0);

      do_frame(1'b0, 5'h11, 5'h04, 16'hBEEF, 3'd2, 1'b0);
      do_frame(1'b1, 5'h03, 5'h1E, 16'h8001, 3'd1, 1'b0);
      do_frame(1'b0, 5'h1F, 5'h1F, 16'h0000, 3'd0, 1'b0);
      do_frame(1'b1, 5'h00, 5'h00, 16'hFFFF, 3'd0, 1'b0);
      do_frame(1'b0, 5'h0A, 5'h15, 16'h5A3C, 3'd1, 1'b1);
      do_frame(1'b1, 5'h15, 5'h0A, 16'hC3A5, 3'd2, 1'b1);

      // R3: read bit written 1 while stored 1 starts nothing
      wr(3'd1, 32'd1);
      wait_idle(v);
      wr(3'd1, 32'd1);
      rd(3'd5, v);
      check("R3 repeated read bit ignored", {32'd0, v}, 64'd0);
      wr(3'd1, 32'd0);

      // R8: abort a read in flight
      wr(3'd0, 32'd3);
      cap_n = 0;
      wr(3'd1, 32'd1);
      repeat (40) @(negedge clk);
      wr(3'd0, 32'h0000_0080);
      rd(3'd5, v);
      check("R8 abort clears indicator", {32'd0, v}, 64'd0);
      check("R8 abort pins", {62'd0, mdc, mdio_oe}, 64'd0);
      rd(3'd0, v);
      check("R8 divider kept by abort", {32'd0, v}, 64'd3);
      wr(3'd0, 32'd1);
      rd(3'd0, v);
      check("R8 divider load", {32'd0, v}, 64'd1);
      wr(3'd1, 32'd0);

      for (int i = 0; i < 8; i++) begin
         do_frame(1'($urandom % 2), 5'($urandom), 5'($urandom), 16'($urandom),
                  3'($urandom % 4), 1'b0);
      end

      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule